// File: doc/BRIEF.md
# Three-Lane Shared-Counter PWM Generator

This block produces three pulse-width modulated outputs from one free-running 8-bit counter. Each lane compares the counter against its own duty value and drives its output high while the counter is below that value. The duty encoding keeps a lane fully low at zero and never lets it stay high for a whole period. A prescaler in front of the counter can slow the step rate by two or by four. That stretches the period without changing the duty resolution.

Software reaches the block through a plain write strobe with an address and data, plus a combinational read port. Duty writes go into a holding register. A holding register is copied into its lane's live compare register only at the moment the counter rolls over from its top value to zero. A period already in progress therefore always finishes with the old duty. The outputs feed a pin multiplexer outside this block. Register access is a simple strobe and no lane carries a data stream, so the block has no valid/ready handshake and no back-pressure.

Top module: `pwm_triple`

## Requirements
- R1: After reset every holding register, every live compare register and the control field are zero, all register reads return 0x00, and all outputs are low.
- R2: An output is high while the shared counter is strictly below its lane's live duty value and low otherwise. Over any window of one full period, the output is high for duty × divide-ratio clock cycles, and each high stretch is one contiguous run.
- R3: A live duty value of 0x00 holds the lane low for the entire period.
- R4: A live duty value of 0xFF gives 255 high steps out of 256. The output is low while the counter sits at 0xFF, so no lane is ever high for a whole period.
- R5: A duty write changes only the holding register. The live compare value takes the new duty at the step where the counter goes from 0xFF to 0x00, and the output does not change before that step.
- R6: The 3-bit byte address maps lane 0, lane 1 and lane 2 to offsets 0x0, 0x2 and 0x4, and the control register to offset 0x6. Writes to the odd offsets change no register, and reads of the odd offsets return 0x00.
- R7: Control bits [1:0] select the step rate: 00 steps the counter on every clock, 01 on every second clock, and 10 or 11 on every fourth clock. Bits [7:2] are not stored, and a read of the control register returns {6'b0, bits[1:0]}.
- R8: Every write to the control register restarts the prescaler phase. In a divided mode, control writes repeated more often than the divide ratio therefore hold the counter still, and stepping resumes once the writes stop.
- R9: The counter advances by exactly one on each prescaler step, wraps from 0xFF to 0x00, and is shared by all lanes. Lanes that hold equal live duty values have identical outputs on every cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock; all state changes on its rising edge |
| rst_n | input | 1 | Active-low synchronous reset |
| wr_en | input | 1 | Write strobe for one cycle, sampled on the rising edge |
| addr | input | 3 | Byte offset for reads and writes |
| wdata | input | 8 | Write data |
| rdata | output | 8 | Combinational read data for `addr` (holding register or control field) |
| pwm_out | output | 3 | One modulated output per lane, bit n for lane n |

## Verification
The prescaler restart on a control write is the hardest behaviour to see from the pins. The counter cannot be read, and a single restart only moves the phase by a few clocks. The stimulus sets divide-by-four with lane 0 at half duty, then rewrites the same control value every second clock for a thousand clocks. If the restart is honoured, the output stays frozen for the whole stretch. Without it, the counter would move about 250 steps and must cross the high/low boundary. The check that a held write takes effect only at the wrap is similar: it is timed from reset, so the counter's phase is known when the write lands.

// File: rtl/pwm_tri_pkg.sv
package pwm_tri_pkg;

  // Step-rate selections held in the control field.
  typedef enum logic [1:0] {
    RATE_FULL = 2'b00,
    RATE_HALF = 2'b01,
    RATE_QTR  = 2'b10,
    RATE_QTRB = 2'b11
  } rate_sel_e;

  localparam int unsigned PRE_W = 2;

  // Terminal prescaler count for a selection: a step is issued when the
  // phase counter equals this value.
  function automatic logic [PRE_W-1:0] rate_limit(input logic [1:0] sel);
    logic [PRE_W-1:0] lim;
    if (sel[1])      lim = PRE_W'(3);
    else if (sel[0]) lim = PRE_W'(1);
    else             lim = PRE_W'(0);
    return lim;
  endfunction

endpackage

// File: rtl/pwm_prescale.sv
module pwm_prescale
  import pwm_tri_pkg::*;
(
  input  logic       clk,
  input  logic       rst_n,
  input  logic [1:0] sel,
  input  logic       restart,
  output logic       step
);

  logic [PRE_W-1:0] phase_q;
  logic [PRE_W-1:0] limit;

  assign limit = rate_limit(sel);
  assign step  = (phase_q == limit);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      phase_q <= '0;
    end else if (restart) begin
      phase_q <= '0;
    end else if (step) begin
      phase_q <= '0;
    end else begin
      phase_q <= phase_q + 1'b1;
    end
  end

endmodule

// File: rtl/pwm_timebase.sv
module pwm_timebase #(
  parameter int unsigned CW = 8
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          step,
  output logic [CW-1:0] cnt,
  output logic          wrap
);

  logic [CW-1:0] cnt_q;

  assign cnt  = cnt_q;
  assign wrap = step && (cnt_q == {CW{1'b1}});

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      cnt_q <= '0;
    end else if (step) begin
      cnt_q <= cnt_q + 1'b1;
    end
  end

endmodule

// File: rtl/pwm_regfile.sv
module pwm_regfile #(
  parameter int unsigned NCH = 3,
  parameter int unsigned DW  = 8,
  parameter int unsigned AW  = 3
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_en,
  input  logic [AW-1:0]     addr,
  input  logic [DW-1:0]     wdata,
  output logic [DW-1:0]     rdata,
  output logic [NCH*DW-1:0] held_flat,
  output logic [1:0]        rate_sel,
  output logic              ctrl_wr
);

  localparam int unsigned SW = AW - 1;

  logic          even;
  logic [SW-1:0] slot;
  logic [DW-1:0] held_q [NCH];
  logic [1:0]    rate_q;

  assign even     = !addr[0];
  assign slot     = addr[AW-1:1];
  assign ctrl_wr  = wr_en && even && (slot == SW'(NCH));
  assign rate_sel = rate_q;

  for (genvar g = 0; g < NCH; g++) begin : g_hold
    always_ff @(posedge clk) begin
      if (!rst_n) begin
        held_q[g] <= '0;
      end else if (wr_en && even && (slot == SW'(g))) begin
        held_q[g] <= wdata;
      end
    end
    assign held_flat[g*DW +: DW] = held_q[g];
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      rate_q <= '0;
    end else if (ctrl_wr) begin
      rate_q <= wdata[1:0];
    end
  end

  always_comb begin
    rdata = '0;
    if (even) begin
      for (int i = 0; i < NCH; i++) begin
        if (slot == SW'(i)) rdata = held_q[i];
      end
      if (slot == SW'(NCH)) rdata = DW'(rate_q);
    end
  end

endmodule

// File: rtl/pwm_lane.sv
module pwm_lane #(
  parameter int unsigned DW = 8
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          load,
  input  logic [DW-1:0] held,
  input  logic [DW-1:0] cnt,
  output logic [DW-1:0] live,
  output logic          pin
);

  logic [DW-1:0] live_q;

  assign live = live_q;
  assign pin  = (cnt < live_q);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      live_q <= '0;
    end else if (load) begin
      live_q <= held;
    end
  end

endmodule

// File: rtl/pwm_triple.sv
module pwm_triple #(
  parameter int unsigned NCH = 3,
  parameter int unsigned DW  = 8,
  parameter int unsigned AW  = 3
) (
  input  logic           clk,
  input  logic           rst_n,
  input  logic           wr_en,
  input  logic [AW-1:0]  addr,
  input  logic [DW-1:0]  wdata,
  output logic [DW-1:0]  rdata,
  output logic [NCH-1:0] pwm_out
);

  logic [NCH*DW-1:0] held_flat;
  logic [NCH*DW-1:0] live_flat;
  logic [1:0]        rate_sel;
  logic              ctrl_wr;
  logic              step;
  logic              wrap;
  logic [DW-1:0]     cnt_q;

  pwm_regfile #(.NCH(NCH), .DW(DW), .AW(AW)) u_regs (
    .clk       (clk),
    .rst_n     (rst_n),
    .wr_en     (wr_en),
    .addr      (addr),
    .wdata     (wdata),
    .rdata     (rdata),
    .held_flat (held_flat),
    .rate_sel  (rate_sel),
    .ctrl_wr   (ctrl_wr)
  );

  pwm_prescale u_pre (
    .clk     (clk),
    .rst_n   (rst_n),
    .sel     (rate_sel),
    .restart (ctrl_wr),
    .step    (step)
  );

  pwm_timebase #(.CW(DW)) u_tb (
    .clk   (clk),
    .rst_n (rst_n),
    .step  (step),
    .cnt   (cnt_q),
    .wrap  (wrap)
  );

  for (genvar g = 0; g < NCH; g++) begin : g_lane
    pwm_lane #(.DW(DW)) u_lane (
      .clk   (clk),
      .rst_n (rst_n),
      .load  (wrap),
      .held  (held_flat[g*DW +: DW]),
      .cnt   (cnt_q),
      .live  (live_flat[g*DW +: DW]),
      .pin   (pwm_out[g])
    );
  end

endmodule

// File: rtl/pwm_triple_chk.sv
module pwm_triple_chk #(
  parameter int unsigned NCH = 3,
  parameter int unsigned DW  = 8,
  parameter int unsigned AW  = 3
) (
  input logic              clk,
  input logic              rst_n,
  input logic              wr_en,
  input logic [AW-1:0]     addr,
  input logic [DW-1:0]     wdata,
  input logic [NCH-1:0]    pwm_out,
  input logic [DW-1:0]     cnt,
  input logic              step,
  input logic              wrap,
  input logic [NCH*DW-1:0] live
);

  localparam logic [AW-1:0] CTRL_OFS = AW'(2 * NCH);

  logic ctrl_hit;
  assign ctrl_hit = wr_en && (addr == CTRL_OFS);

  // R1
  reset_state_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !$past(rst_n) |-> (pwm_out == '0) && (cnt == '0) && (live == '0));

  // R9
  step_advance_chk: assert property (@(posedge clk) disable iff (!rst_n)
    step |=> (cnt == DW'($past(cnt) + 1'b1)));

  // R9
  idle_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !step |=> $stable(cnt));

  // R5
  live_wrap_only_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !wrap |=> $stable(live));

  // R4
  top_count_low_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (cnt == {DW{1'b1}}) |-> (pwm_out == '0));

  // R8
  restart_gap_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (ctrl_hit && (wdata[1:0] != 2'b00)) |=> !step);

  for (genvar g = 0; g < NCH; g++) begin : g_lane_chk
    // R3
    zero_duty_low_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (live[g*DW +: DW] == '0) |-> !pwm_out[g]);
  end

endmodule

bind pwm_triple pwm_triple_chk #(.NCH(NCH), .DW(DW), .AW(AW)) u_chk (
  .clk     (clk),
  .rst_n   (rst_n),
  .wr_en   (wr_en),
  .addr    (addr),
  .wdata   (wdata),
  .pwm_out (pwm_out),
  .cnt     (cnt_q),
  .step    (step),
  .wrap    (wrap),
  .live    (live_flat)
);

// File: tb/test_pwm_triple.sv
`timescale 1ns/1ps
module test_pwm_triple;

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       wr_en = 1'b0;
  logic [2:0] addr = '0;
  logic [7:0] wdata = '0;
  logic [7:0] rdata;
  logic [2:0] pwm_out;

  int n_chk = 0;
  int n_bad = 0;
  bit done = 1'b0;

  always #2.5 clk = ~clk;

  pwm_triple i_pwm_triple (
    .clk     (clk),
    .rst_n   (rst_n),
    .wr_en   (wr_en),
    .addr    (addr),
    .wdata   (wdata),
    .rdata   (rdata),
    .pwm_out (pwm_out)
  );

  task automatic check(input bit ok, input string req, input int act, input int exp);
    n_chk++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic wr(input logic [2:0] a, input logic [7:0] d);
    @(negedge clk);
    wr_en = 1'b1; addr = a; wdata = d;
    @(negedge clk);
    wr_en = 1'b0;
  endtask

  task automatic rd(input logic [2:0] a, output logic [7:0] d);
    @(negedge clk);
    addr = a;
    #1 d = rdata;
  endtask

  // Counts high cycles per lane over n cycles; flags any lane mismatch.
  task automatic measure(input int n, output int h0, output int h1, output int h2,
                         output bit same);
    h0 = 0; h1 = 0; h2 = 0; same = 1'b1;
    for (int i = 0; i < n; i++) begin
      @(negedge clk);
      h0 += int'(pwm_out[0]);
      h1 += int'(pwm_out[1]);
      h2 += int'(pwm_out[2]);
      if (!(pwm_out[0] == pwm_out[1] && pwm_out[1] == pwm_out[2])) same = 1'b0;
    end
  endtask

  task automatic t_reset();
    logic [7:0] v;
    for (int a = 0; a < 8; a += 2) begin
      rd(3'(a), v);
      check(v == 8'h00, "R1 register read after reset", int'(v), 0);
    end
    check(pwm_out == 3'b000, "R1 outputs low after reset", int'(pwm_out), 0);
  endtask

  // Timed from reset: counter is near 8 when the write lands.
  task automatic t_shadow();
    int lows = 0;
    int highs = 0;
    wr(3'h0, 8'h80);
    while (pwm_out[0] == 1'b0 && lows < 400) begin
      @(negedge clk);
      lows++;
    end
    check(lows >= 200 && lows <= 256, "R5 new duty waits for counter wrap", lows, 240);
    while (pwm_out[0] == 1'b1 && highs < 400) begin
      @(negedge clk);
      highs++;
    end
    check(highs == 128, "R2 contiguous high run at full rate", highs, 128);
  endtask

  task automatic t_map();
    logic [7:0] v;
    wr(3'h0, 8'h11); wr(3'h2, 8'h22); wr(3'h4, 8'h33); wr(3'h6, 8'hFD);
    for (int a = 1; a < 8; a += 2) wr(3'(a), 8'hAA);
    rd(3'h0, v); check(v == 8'h11, "R6 lane 0 at offset 0", int'(v), 'h11);
    rd(3'h2, v); check(v == 8'h22, "R6 lane 1 at offset 2", int'(v), 'h22);
    rd(3'h4, v); check(v == 8'h33, "R6 lane 2 at offset 4", int'(v), 'h33);
    rd(3'h6, v); check(v == 8'h01, "R7 control keeps only bits 1:0", int'(v), 1);
    for (int a = 1; a < 8; a += 2) begin
      rd(3'(a), v);
      check(v == 8'h00, "R6 odd offset reads zero", int'(v), 0);
    end
    wr(3'h6, 8'h00);
  endtask

  task automatic t_duty(input logic [1:0] sel, input logic [7:0] d0,
                        input logic [7:0] d1, input logic [7:0] d2, input string req);
    int div;
    int h0, h1, h2;
    bit same;
    logic [7:0] v;
    div = sel[1] ? 4 : (sel[0] ? 2 : 1);
    wr(3'h6, {6'b0, sel});
    wr(3'h0, d0); wr(3'h2, d1); wr(3'h4, d2);
    rd(3'h6, v);
    check(v == {6'b0, sel}, "R7 control readback", int'(v), int'(sel));
    repeat (256 * div + 8) @(negedge clk);
    measure(256 * div, h0, h1, h2, same);
    check(h0 == int'(d0) * div, req, h0, int'(d0) * div);
    check(h1 == int'(d1) * div, req, h1, int'(d1) * div);
    check(h2 == int'(d2) * div, req, h2, int'(d2) * div);
    if (d0 == d1 && d1 == d2) check(same, "R9 shared counter equal lanes", int'(same), 1);
  endtask

  task automatic t_restart();
    logic ref0;
    int moved = 0;
    int wait_n = 0;
    wr(3'h6, 8'h02);
    wr(3'h0, 8'h80);
    repeat (1100) @(negedge clk);
    ref0 = pwm_out[0];
    for (int i = 0; i < 500; i++) begin
      wr(3'h6, 8'h02);
      if (pwm_out[0] != ref0) moved++;
    end
    check(moved == 0, "R8 repeated control writes hold counter", moved, 0);
    while (pwm_out[0] == ref0 && wait_n < 1100) begin
      @(negedge clk);
      wait_n++;
    end
    check(wait_n < 1100, "R8 stepping resumes after writes stop", wait_n, 512);
  endtask

  initial begin
    repeat (5) @(negedge clk);
    rst_n = 1'b1;
    t_reset();
    t_shadow();
    t_map();
    t_duty(2'b00, 8'h00, 8'hFF, 8'h40, "R2 R3 R4 full-rate high count");
    t_duty(2'b01, 8'h01, 8'h80, 8'hFE, "R2 R7 half-rate high count");
    t_duty(2'b10, 8'hFF, 8'h00, 8'h10, "R3 R4 R7 quarter-rate high count");
    t_duty(2'b11, 8'h55, 8'h55, 8'h55, "R7 R9 quarter-rate alias high count");
    t_restart();
    done = 1'b1;
  end

  initial begin
    int cyc = 0;
    while (!done && cyc < 150000) begin
      @(posedge clk);
      cyc++;
    end
    if (!done) begin
      n_chk++;
      n_bad++;
      $display("FAIL watchdog expired actual=%0d expected=%0d", cyc, 0);
    end
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_bad);
    $finish;
  end

endmodule